// File: doc/BRIEF.md
# Feed-Protected Clock Source Controller

This block holds the settings for an external frequency-multiplying PLL and decides whether the system clock comes from the PLL or from the reference oscillator. Software writes the control word (enable and connect) and the configuration word (multiplier and divider) through a simple register interface. These writes only land in pending copies. The active copies, which drive the PLL and the clock-select output, change only after an unlock sequence of two writes to a feed register.

The PLL reports its lock state on an asynchronous input, which is synchronized inside the block. The select output, consumed by a separate glitch-free multiplexer, is high only while the PLL is enabled, connected and locked. The connect request is accepted only while lock is present. If lock drops, the block clears its active connect bit on its own, so the clock falls back to the oscillator and stays there until software connects again.

Top module: `clksrc_ctrl`

## Requirements
- R1: The control word sits at offset 0, with enable in bit 0 and connect in bit 1. The configuration word sits at offset 1, with the multiplier in bits [4:0] and the divider in bits [6:5]. Both read back their pending values at their own offsets.
- R2: Writes to offsets 0 and 1 leave `pll_en`, `pll_mul`, `pll_div`, `clk_sel` and the status word unchanged until an unlock completes.
- R3: A write of 0x00AA to the feed register (offset 3), followed by a write of 0x0055 to it as the next bus access, copies the pending values to the active ones on the clock edge of the 0x0055 write. Idle cycles between the two writes are allowed.
- R4: Between the 0x00AA and the 0x0055, any of the following aborts the sequence and leaves the active values unchanged: a read, a write to another offset, or a feed write of any other value. A repeated 0x00AA keeps the sequence armed.
- R5: `pll_en`, `pll_mul` and `pll_div` always equal the active enable, multiplier and divider values.
- R6: The status word at offset 2 is laid out as follows: bit 0 holds the active enable, bit 1 the active connect, bit 2 the synchronized lock, bits [7:3] the active multiplier and bits [9:8] the active divider. All other bits read zero, and so does offset 3.
- R7: `clk_sel` is high only when the active enable, the active connect and the synchronized lock are all high. The lock is seen two clock edges after `pll_lock` changes.
- R8: When the synchronized lock falls while connected, the active connect clears on the next edge and `clk_sel` goes low. Both stay low after lock returns, until a new unlock.
- R9: An unlock whose pending enable is clear leaves the active connect at 0, even if the pending connect is set.
- R10: An unlock while the synchronized lock is low leaves the active connect at 0.
- R11: After reset, all active and pending values are zero and `clk_sel` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed offset |
| pll_lock | input | 1 | Asynchronous lock indication from the PLL |
| pll_en | output | 1 | Active PLL enable |
| pll_mul | output | 5 | Active multiplier field |
| pll_div | output | 2 | Active divider field |
| clk_sel | output | 1 | 1 selects the PLL clock, 0 the oscillator |

## Verification
Some properties are checked on every cycle by assertions:
- the select output never rises without enable and synchronized lock;
- the active connect never stands without enable;
- a connected state without lock always clears on the next edge;
- the active settings change only on an unlock edge, and then take the pending values;
- a read always aborts an armed sequence.

Other behaviour can only be shown by the bench's scenarios: the exact unlock orderings that succeed or fail, the field positions of each register, the two-cycle lock latency, and the fact that the fallback persists after lock returns.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;
  localparam int CSC_DATA_W = 16;
  localparam int CSC_MUL_W  = 5;
  localparam int CSC_DIV_W  = 2;

  typedef enum logic [1:0] {
    OFS_CTRL   = 2'd0,
    OFS_CFG    = 2'd1,
    OFS_STATUS = 2'd2,
    OFS_FEED   = 2'd3
  } csc_ofs_e;

  localparam logic [15:0] UNLOCK_FIRST  = 16'h00AA;
  localparam logic [15:0] UNLOCK_SECOND = 16'h0055;

  // connect is granted only with enable requested and lock present
  function automatic logic grant_connect(input logic en, input logic conn, input logic lock);
    return en & conn & lock;
  endfunction
endpackage

// File: rtl/clksrc_lock_sync.sv
module clksrc_lock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_async,
  output logic lock_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], lock_async};
  end

  assign lock_sync = chain[STAGES-1];
endmodule

// File: rtl/clksrc_feed.sv
module clksrc_feed
  import clksrc_pkg::*;
#(
  parameter int DATA_W = CSC_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              apply
);
  logic armed;
  logic access;
  logic feed_wr;
  logic first_word;

  assign access     = bus_wr | bus_rd;
  assign feed_wr    = bus_wr && (bus_addr == OFS_FEED);
  assign first_word = feed_wr && (bus_wdata == DATA_W'(UNLOCK_FIRST));
  assign apply      = armed && feed_wr && (bus_wdata == DATA_W'(UNLOCK_SECOND));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed <= 1'b0;
    else if (access) armed <= first_word;
  end

  AST_READ_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> !apply); // R4
  AST_OTHER_OFS_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != OFS_FEED) |=> !apply); // R4
endmodule

// File: rtl/clksrc_active.sv
module clksrc_active
  import clksrc_pkg::*;
#(
  parameter int MUL_W = CSC_MUL_W,
  parameter int DIV_W = CSC_DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             apply,
  input  logic             pend_en,
  input  logic             pend_conn,
  input  logic [MUL_W-1:0] pend_mul,
  input  logic [DIV_W-1:0] pend_div,
  input  logic             lock_s,
  output logic             act_en,
  output logic             act_conn,
  output logic [MUL_W-1:0] act_mul,
  output logic [DIV_W-1:0] act_div,
  output logic             clk_sel
);
  logic lock_lost;

  assign lock_lost = act_conn & ~lock_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_en   <= 1'b0;
      act_conn <= 1'b0;
      act_mul  <= '0;
      act_div  <= '0;
    end else if (apply) begin
      act_en   <= pend_en;
      act_conn <= grant_connect(pend_en, pend_conn, lock_s);
      act_mul  <= pend_mul;
      act_div  <= pend_div;
    end else if (lock_lost) begin
      act_conn <= 1'b0;
    end
  end

  assign clk_sel = act_en & act_conn & lock_s;

  AST_SEL_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sel |-> (pll_state_ok(act_en, lock_s))); // R7
  AST_CONN_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    act_conn |-> act_en); // R9
  AST_LOSS_DISCONNECTS: assert property (@(posedge clk) disable iff (!rst_n)
    (act_conn && !lock_s) |=> !act_conn); // R8
  AST_HOLD_WITHOUT_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable({act_en, act_mul, act_div})); // R2
  AST_APPLY_TAKES_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> (act_mul == $past(pend_mul) && act_div == $past(pend_div)
               && act_en == $past(pend_en))); // R3

  function automatic logic pll_state_ok(input logic en, input logic lk);
    return en & lk;
  endfunction
endmodule

// File: rtl/clksrc_ctrl.sv
module clksrc_ctrl
  import clksrc_pkg::*;
#(
  parameter int DATA_W      = CSC_DATA_W,
  parameter int MUL_W       = CSC_MUL_W,
  parameter int DIV_W       = CSC_DIV_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              pll_lock,
  output logic              pll_en,
  output logic [MUL_W-1:0]  pll_mul,
  output logic [DIV_W-1:0]  pll_div,
  output logic              clk_sel
);
  localparam int CFG_W  = MUL_W + DIV_W;
  localparam int STAT_W = 3 + CFG_W;

  logic             pend_en, pend_conn;
  logic [MUL_W-1:0] pend_mul;
  logic [DIV_W-1:0] pend_div;
  logic             apply, lock_s;
  logic             act_en, act_conn;
  logic [MUL_W-1:0] act_mul;
  logic [DIV_W-1:0] act_div;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_en   <= 1'b0;
      pend_conn <= 1'b0;
      pend_mul  <= '0;
      pend_div  <= '0;
    end else if (bus_wr) begin
      if (bus_addr == OFS_CTRL) begin
        pend_en   <= bus_wdata[0];
        pend_conn <= bus_wdata[1];
      end
      if (bus_addr == OFS_CFG) begin
        pend_mul <= bus_wdata[MUL_W-1:0];
        pend_div <= bus_wdata[CFG_W-1:MUL_W];
      end
    end
  end

  clksrc_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .lock_async(pll_lock), .lock_sync(lock_s)
  );

  clksrc_feed #(.DATA_W(DATA_W)) u_feed (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .apply(apply)
  );

  clksrc_active #(.MUL_W(MUL_W), .DIV_W(DIV_W)) u_act (
    .clk(clk), .rst_n(rst_n), .apply(apply),
    .pend_en(pend_en), .pend_conn(pend_conn), .pend_mul(pend_mul), .pend_div(pend_div),
    .lock_s(lock_s), .act_en(act_en), .act_conn(act_conn),
    .act_mul(act_mul), .act_div(act_div), .clk_sel(clk_sel)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_CTRL:   bus_rdata[1:0] = {pend_conn, pend_en};
      OFS_CFG:    bus_rdata[CFG_W-1:0] = {pend_div, pend_mul};
      OFS_STATUS: bus_rdata[STAT_W-1:0] = {act_div, act_mul, lock_s, act_conn, act_en};
      default:    bus_rdata = '0;
    endcase
  end

  assign pll_en  = act_en;
  assign pll_mul = act_mul;
  assign pll_div = act_div;

  AST_OUT_NOT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != OFS_FEED) |=> $stable({pll_en, pll_mul, pll_div})); // R2
endmodule

// File: tb/sim_clksrc_ctrl.sv
`timescale 1ns/1ps
module sim_clksrc_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic pll_lock = 1'b0;
  logic pll_en, clk_sel;
  logic [4:0] pll_mul;
  logic [1:0] pll_div;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  clksrc_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pll_lock(pll_lock),
    .pll_en(pll_en), .pll_mul(pll_mul), .pll_div(pll_div), .clk_sel(clk_sel)
  );

  // {en, conn, mul[4:0], div[1:0]} applied with lock present
  localparam logic [8:0] VEC [6] = '{
    {1'b1, 1'b0, 5'd9,  2'd1},
    {1'b1, 1'b1, 5'd4,  2'd2},
    {1'b1, 1'b1, 5'd31, 2'd3},
    {1'b0, 1'b1, 5'd17, 2'd0},
    {1'b1, 1'b1, 5'd1,  2'd0},
    {1'b0, 1'b0, 5'd0,  2'd0}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic unlock();
    wr(2'd3, 16'h00AA);
    wr(2'd3, 16'h0055);
  endtask

  function automatic logic [15:0] stat(input logic en, input logic cn, input logic lk,
                                       input logic [4:0] m, input logic [1:0] dv);
    return 16'(en) | (16'(cn) << 1) | (16'(lk) << 2) | (16'(m) << 3) | (16'(dv) << 8);
  endfunction

  task automatic set_lock(input logic v);
    @(negedge clk); pll_lock = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 outputs", {pll_en, clk_sel, pll_mul, pll_div}, 16'h0);
    rd(2'd2, r); chk("R11 status", r, 16'h0);
    rd(2'd0, r); chk("R11 pending ctrl", r, 16'h0);

    set_lock(1'b1);
    foreach (VEC[i]) begin
      logic en, cn; logic [4:0] m; logic [1:0] dv;
      {en, cn, m, dv} = VEC[i];
      wr(2'd0, {14'd0, cn, en});
      wr(2'd1, {9'd0, dv, m});
      rd(2'd1, r); chk("R1 pending cfg", r, {9'd0, dv, m});
      unlock();
      chk("R3 R5 outputs", {8'd0, pll_en, pll_mul, pll_div}, {8'd0, en, m, dv});
      chk("R7 R9 clk_sel", {15'd0, clk_sel}, {15'd0, en & cn});
      rd(2'd2, r); chk("R6 status", r, stat(en, en & cn, 1'b1, m, dv));
    end

    // R2 pending writes do not reach outputs
    wr(2'd0, 16'h0003); wr(2'd1, 16'h0055);
    rd(2'd0, r); chk("R1 pending ctrl", r, 16'h0003);
    chk("R2 outputs held", {8'd0, pll_en, pll_mul, pll_div, clk_sel}, 16'h0);
    rd(2'd2, r); chk("R2 status held", r, stat(0, 0, 1, 0, 0));

    // R4 aborts
    wr(2'd3, 16'h00AA); rd(2'd0, r); wr(2'd3, 16'h0055);
    chk("R4 read aborts", {15'd0, pll_en}, 16'h0);
    wr(2'd3, 16'h00AA); wr(2'd1, 16'h0055); wr(2'd3, 16'h0055);
    chk("R4 other offset aborts", {15'd0, pll_en}, 16'h0);
    wr(2'd3, 16'h00AA); wr(2'd3, 16'h0056); wr(2'd3, 16'h0055);
    chk("R4 wrong value aborts", {15'd0, pll_en}, 16'h0);
    rd(2'd3, r); chk("R6 feed reads zero", r, 16'h0);
    // R4 repeated AA keeps armed, idle gap allowed (R3)
    wr(2'd3, 16'h00AA); wr(2'd3, 16'h00AA);
    repeat (4) @(negedge clk);
    wr(2'd3, 16'h0055);
    chk("R4 double AA applies", {8'd0, pll_en, pll_mul, pll_div, clk_sel}, {8'd0, 1'b1, 5'd21, 2'd2, 1'b1});

    // R8 lock loss fallback
    @(negedge clk); pll_lock = 1'b0;
    @(negedge clk);
    chk("R7 sync latency", {15'd0, clk_sel}, 16'h1);
    @(negedge clk);
    chk("R8 sel drops", {15'd0, clk_sel}, 16'h0);
    @(negedge clk);
    rd(2'd2, r); chk("R8 connect cleared", r, stat(1, 0, 0, 5'd21, 2'd2));
    set_lock(1'b1);
    chk("R8 stays off after relock", {15'd0, clk_sel}, 16'h0);
    rd(2'd2, r); chk("R8 status after relock", r, stat(1, 0, 1, 5'd21, 2'd2));

    // R10 connect without lock ignored
    set_lock(1'b0);
    unlock();
    set_lock(1'b1);
    chk("R10 no connect w/o lock", {15'd0, clk_sel}, 16'h0);
    unlock();
    chk("R7 reconnect", {15'd0, clk_sel}, 16'h1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule